// File: doc/BRIEF.md
# Transmit Collision Retry Controller

This block sits beside a transmit FIFO and decides how much of the FIFO the writer may reuse while a frame goes out on a half-duplex link. At the start of each transmission it records where the frame starts. The bytes of the current attempt stay protected until the collision window has passed without a collision. That window is the first 64 bytes on the wire, counting the preamble. If a collision arrives inside the window, the block rewinds the FIFO read pointer to the recorded start and requests a jam. It then waits a random number of slot times before it lets the serializer try again.

A frame may be attempted at most sixteen times. When the sixteenth attempt also collides, the frame is closed with a retry-error status. A collision after the window is treated as a late collision: the frame is aborted without a rewind. A dropped carrier during transmission is recorded and reported when the frame ends. In full-duplex mode collisions and carrier are ignored. In full-duplex mode, or when retries are switched off, nothing is held back: free space follows the read pointer byte by byte.

The serializer drives `bit_tick` once per bit time. Jam length and slot length are counted in these ticks.

Top module: `txretry_ctrl`

## Requirements
- R1: When `frame_end` is sampled during an attempt and no collision is sampled in the same cycle, `done` pulses for one cycle on the next edge with `status` = 4'b0001. Status bits are: bit 0 success, bit 1 retry error, bit 2 late collision, bit 3 carrier loss.
- R2: In half duplex with retries enabled, `free_ptr` holds the frame-start pointer until WIN_BYTES `byte_sent` pulses of the current attempt have been counted. One cycle after that it follows `rd_ptr`.
- R3: A collision sampled in half duplex after fewer than WIN_BYTES bytes of an attempt that is not the last one gives a one-cycle `rewind` pulse on the next edge, with `rewind_ptr` equal to the frame-start pointer.
- R4: In full-duplex mode `collision` is ignored, with no rewind and no jam. When `full_duplex` or `retry_dis` is set, `free_ptr` follows `rd_ptr` with one cycle of delay.
- R5: A frame is attempted at most MAX_ATT (16) times. A collision inside the window on attempt 16 ends the frame with `status` = 4'b0010, with no rewind and no `retry_go`. Fifteen collisions followed by a clean attempt end with 4'b0001.
- R6: A collision sampled after WIN_BYTES bytes of the attempt is a late collision. It causes no rewind and ends the frame after the jam with `status` = 4'b0100.
- R7: With `retry_dis` set, any collision in half duplex ends the frame after the jam with `status` = 4'b0010 and no rewind.
- R8: If `carrier` is low in any cycle of a half-duplex attempt, status bit 3 is set in the frame's final status. In full duplex, carrier is ignored.
- R9: After each collision that is not ignored, `jam_req` is high for exactly JAM_BITS bit ticks. A frame with no retry reports `done` on the edge where `jam_req` falls.
- R10: After the jam of attempt n, `retry_go` pulses after r slot times of SLOT_BITS bit ticks, with 0 <= r < 2^min(n,10).
- R11: `attempt_num` reads 1 after `tx_start` and rises by one with each `retry_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One pulse per bit time on the link |
| tx_start | input | 1 | New frame begins its first attempt |
| start_ptr | input | PTR_W | FIFO address of the frame's first byte |
| rd_ptr | input | PTR_W | Current FIFO read pointer |
| byte_sent | input | 1 | One byte of the frame has gone onto the wire |
| frame_end | input | 1 | Last byte of the frame has been sent |
| collision | input | 1 | Collision detected |
| carrier | input | 1 | Carrier sense |
| full_duplex | input | 1 | Link in full-duplex mode |
| retry_dis | input | 1 | Disable automatic retry and retention |
| rewind | output | 1 | Reload read pointer pulse |
| rewind_ptr | output | PTR_W | Value to reload into the read pointer |
| free_ptr | output | PTR_W | Writer may overwrite up to this address |
| jam_req | output | 1 | Request jam transmission |
| backoff_busy | output | 1 | Random backoff in progress |
| retry_go | output | 1 | Start the next attempt |
| done | output | 1 | Frame finished pulse |
| status | output | 4 | Final status of the last frame |
| attempt_num | output | ATT_W | Current attempt number |

## Verification
The bench places collisions on both sides of the window edge, at byte 63 and at byte 64. A window counter that is off by one would turn the first into a late collision or the second into a retry. It drives sixteen back-to-back collisions to catch an attempt limit that fires one attempt early or late, and it checks that fifteen collisions followed by a clean attempt still succeed. It times the jam and the backoff against the exponent bound, which catches a short jam or a mask that grows too fast. Full-duplex and retry-disabled frames catch a design that still holds free space, rewinds, or reports carrier loss when it should not.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [1:0] {S_IDLE, S_XMIT, S_JAM, S_WAIT} txr_state_e;

  localparam logic [3:0] ST_OK   = 4'b0001;
  localparam logic [3:0] ST_RTRY = 4'b0010;
  localparam logic [3:0] ST_LATE = 4'b0100;
  localparam logic [3:0] ST_CRS  = 4'b1000;
endpackage

// File: rtl/txr_win_cnt.sv
module txr_win_cnt #(
  parameter int WIN_BYTES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic byte_sent,
  output logic passed
);
  localparam int CW = $clog2(WIN_BYTES + 1);

  logic [CW-1:0] cnt;

  assign passed = (cnt == CW'(WIN_BYTES));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (byte_sent && !passed) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/txr_backoff.sv
module txr_backoff #(
  parameter int SLOT_BITS = 512,
  parameter int CAP       = 10,
  parameter int ATT_W     = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             bit_tick,
  input  logic [ATT_W-1:0] n,
  output logic             busy,
  output logic             done
);
  localparam int SC_W = (SLOT_BITS > 2) ? $clog2(SLOT_BITS) : 1;

  logic [15:0]     lfsr;
  logic [CAP-1:0]  mask;
  logic [CAP-1:0]  slots_left;
  logic [SC_W-1:0] slot_cnt;
  int              exp_v;

  always_comb begin
    exp_v = (int'(n) > CAP) ? CAP : int'(n);
    for (int i = 0; i < CAP; i++) mask[i] = (i < exp_v);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr       <= 16'hACE1;
      busy       <= 1'b0;
      done       <= 1'b0;
      slots_left <= '0;
      slot_cnt   <= '0;
    end else begin
      lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
      done <= 1'b0;
      if (start) begin
        busy       <= 1'b1;
        slots_left <= lfsr[CAP-1:0] & mask;
        slot_cnt   <= '0;
      end else if (busy) begin
        if (slots_left == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (bit_tick) begin
          if (slot_cnt == SC_W'(SLOT_BITS - 1)) begin
            slot_cnt   <= '0;
            slots_left <= slots_left - 1'b1;
          end else begin
            slot_cnt <= slot_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/txretry_ctrl.sv
module txretry_ctrl
  import txr_pkg::*;
#(
  parameter int PTR_W     = 11,
  parameter int WIN_BYTES = 64,
  parameter int MAX_ATT   = 16,
  parameter int JAM_BITS  = 32,
  parameter int SLOT_BITS = 512,
  parameter int BO_CAP    = 10,
  localparam int ATT_W    = $clog2(MAX_ATT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  logic             tx_start,
  input  logic [PTR_W-1:0] start_ptr,
  input  logic [PTR_W-1:0] rd_ptr,
  input  logic             byte_sent,
  input  logic             frame_end,
  input  logic             collision,
  input  logic             carrier,
  input  logic             full_duplex,
  input  logic             retry_dis,
  output logic             rewind,
  output logic [PTR_W-1:0] rewind_ptr,
  output logic [PTR_W-1:0] free_ptr,
  output logic             jam_req,
  output logic             backoff_busy,
  output logic             retry_go,
  output logic             done,
  output logic [3:0]       status,
  output logic [ATT_W-1:0] attempt_num
);
  localparam int JAM_W = (JAM_BITS > 2) ? $clog2(JAM_BITS) : 1;

  txr_state_e       state;
  logic [PTR_W-1:0] base;
  logic [JAM_W-1:0] jam_cnt;
  logic             retry_pend;
  logic             crs_lost;
  logic [3:0]       end_code;
  logic             win_passed;
  logic             win_clr;
  logic             bo_start;
  logic             bo_done;
  logic             retain;
  logic             col_v;

  assign retain  = !(full_duplex || retry_dis);
  assign col_v   = collision && !full_duplex;
  assign win_clr = (state == S_IDLE && tx_start) || (state == S_WAIT && bo_done);

  txr_win_cnt #(.WIN_BYTES(WIN_BYTES)) win_i (
    .clk(clk), .rst(rst), .clr(win_clr), .byte_sent(byte_sent), .passed(win_passed)
  );

  txr_backoff #(.SLOT_BITS(SLOT_BITS), .CAP(BO_CAP), .ATT_W(ATT_W)) bo_i (
    .clk(clk), .rst(rst), .start(bo_start), .bit_tick(bit_tick),
    .n(attempt_num), .busy(backoff_busy), .done(bo_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      base        <= '0;
      jam_cnt     <= '0;
      retry_pend  <= 1'b0;
      crs_lost    <= 1'b0;
      end_code    <= '0;
      rewind      <= 1'b0;
      rewind_ptr  <= '0;
      free_ptr    <= '0;
      jam_req     <= 1'b0;
      retry_go    <= 1'b0;
      done        <= 1'b0;
      status      <= '0;
      attempt_num <= '0;
      bo_start    <= 1'b0;
    end else begin
      rewind   <= 1'b0;
      retry_go <= 1'b0;
      done     <= 1'b0;
      bo_start <= 1'b0;
      free_ptr <= (state != S_IDLE && retain && !win_passed) ? base : rd_ptr;
      case (state)
        S_IDLE: begin
          if (tx_start) begin
            base        <= start_ptr;
            attempt_num <= ATT_W'(1);
            crs_lost    <= 1'b0;
            state       <= S_XMIT;
          end
        end
        S_XMIT: begin
          if (!full_duplex && !carrier) crs_lost <= 1'b1;
          if (col_v) begin
            jam_req <= 1'b1;
            jam_cnt <= '0;
            state   <= S_JAM;
            if (retry_dis) begin
              retry_pend <= 1'b0;
              end_code   <= ST_RTRY;
            end else if (win_passed) begin
              retry_pend <= 1'b0;
              end_code   <= ST_LATE;
            end else if (attempt_num == ATT_W'(MAX_ATT)) begin
              retry_pend <= 1'b0;
              end_code   <= ST_RTRY;
            end else begin
              retry_pend <= 1'b1;
              rewind     <= 1'b1;
              rewind_ptr <= base;
            end
          end else if (frame_end) begin
            done   <= 1'b1;
            status <= ST_OK | ((crs_lost || (!full_duplex && !carrier)) ? ST_CRS : 4'b0000);
            state  <= S_IDLE;
          end
        end
        S_JAM: begin
          if (bit_tick) begin
            if (jam_cnt == JAM_W'(JAM_BITS - 1)) begin
              jam_req <= 1'b0;
              if (retry_pend) begin
                bo_start <= 1'b1;
                state    <= S_WAIT;
              end else begin
                done   <= 1'b1;
                status <= end_code | (crs_lost ? ST_CRS : 4'b0000);
                state  <= S_IDLE;
              end
            end else begin
              jam_cnt <= jam_cnt + 1'b1;
            end
          end
        end
        S_WAIT: begin
          if (bo_done) begin
            retry_go    <= 1'b1;
            attempt_num <= attempt_num + 1'b1;
            state       <= S_XMIT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txretry_ctrl_chk.sv
module txretry_ctrl_chk #(
  parameter int PTR_W   = 11,
  parameter int ATT_W   = 5,
  parameter int MAX_ATT = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             full_duplex,
  input logic [PTR_W-1:0] rd_ptr,
  input logic             rewind,
  input logic [PTR_W-1:0] free_ptr,
  input logic             jam_req,
  input logic             retry_go,
  input logic             done,
  input logic [3:0]       status,
  input logic [ATT_W-1:0] attempt_num
);
  p_attempt_cap_r5: assert property (@(posedge clk) disable iff (rst)
    attempt_num <= ATT_W'(MAX_ATT));

  p_rewind_jams_r3: assert property (@(posedge clk) disable iff (rst)
    rewind |-> jam_req);

  p_fd_no_rewind_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(full_duplex) && !$past(rst)) |-> !rewind);

  p_fd_free_follows_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(full_duplex) && !$past(rst)) |-> free_ptr == $past(rd_ptr));

  p_done_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
    done |-> !(status[0] && (status[1] || status[2])));

  p_go_after_jam_r10: assert property (@(posedge clk) disable iff (rst)
    retry_go |-> !jam_req);
endmodule

bind txretry_ctrl txretry_ctrl_chk #(
  .PTR_W(PTR_W), .ATT_W(ATT_W), .MAX_ATT(MAX_ATT)
) chk_i (
  .clk(clk), .rst(rst), .full_duplex(full_duplex), .rd_ptr(rd_ptr),
  .rewind(rewind), .free_ptr(free_ptr), .jam_req(jam_req), .retry_go(retry_go),
  .done(done), .status(status), .attempt_num(attempt_num)
);

// File: tb/txretry_ctrl_tb_top.sv
module txretry_ctrl_tb_top;
  localparam int PTR_W = 11;
  localparam int SLOT  = 4;
  localparam int JAM   = 32;
  localparam int ATT_W = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             bit_tick = 1'b1;
  logic             tx_start = 1'b0;
  logic [PTR_W-1:0] start_ptr = '0;
  logic [PTR_W-1:0] rd_ptr = '0;
  logic             byte_sent = 1'b0;
  logic             frame_end = 1'b0;
  logic             collision = 1'b0;
  logic             carrier = 1'b1;
  logic             full_duplex = 1'b0;
  logic             retry_dis = 1'b0;
  logic             rewind, jam_req, backoff_busy, retry_go, done;
  logic [PTR_W-1:0] rewind_ptr, free_ptr;
  logic [3:0]       status;
  logic [ATT_W-1:0] attempt_num;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  txretry_ctrl #(.PTR_W(PTR_W), .SLOT_BITS(SLOT), .JAM_BITS(JAM)) dut_i (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_start(tx_start),
    .start_ptr(start_ptr), .rd_ptr(rd_ptr), .byte_sent(byte_sent),
    .frame_end(frame_end), .collision(collision), .carrier(carrier),
    .full_duplex(full_duplex), .retry_dis(retry_dis), .rewind(rewind),
    .rewind_ptr(rewind_ptr), .free_ptr(free_ptr), .jam_req(jam_req),
    .backoff_busy(backoff_busy), .retry_go(retry_go), .done(done),
    .status(status), .attempt_num(attempt_num)
  );

  typedef struct packed {
    logic       fd;
    logic       rdis;
    logic [7:0] col_at;
    logic [7:0] len;
    logic       crs;
    logic       rw;
    logic [3:0] st;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{1'b0, 1'b0, 8'hFF, 8'd80, 1'b0, 1'b0, 4'b0001},  // R1 clean frame
    '{1'b0, 1'b0, 8'd10, 8'd80, 1'b0, 1'b1, 4'b0001},  // R3 early collision retried
    '{1'b0, 1'b0, 8'd70, 8'd80, 1'b0, 1'b0, 4'b0100},  // R6 late collision
    '{1'b1, 1'b0, 8'd10, 8'd80, 1'b0, 1'b0, 4'b0001},  // R4 full duplex ignores collision
    '{1'b0, 1'b1, 8'd10, 8'd80, 1'b0, 1'b0, 4'b0010},  // R7 retry disabled
    '{1'b0, 1'b0, 8'hFF, 8'd80, 1'b1, 1'b0, 4'b1001},  // R8 carrier loss
    '{1'b1, 1'b0, 8'hFF, 8'd80, 1'b1, 1'b0, 4'b0001},  // R8 carrier ignored in full duplex
    '{1'b0, 1'b0, 8'd63, 8'd80, 1'b0, 1'b1, 4'b0001},  // R3 last byte inside window
    '{1'b0, 1'b0, 8'd64, 8'd80, 1'b0, 1'b0, 4'b0100}   // R6 first byte past window
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_frame(input logic [PTR_W-1:0] b);
    @(negedge clk); tx_start = 1'b1; start_ptr = b; rd_ptr = b;
    @(negedge clk); tx_start = 1'b0;
  endtask

  task automatic send_byte(input bit drop);
    @(negedge clk); byte_sent = 1'b1; rd_ptr = rd_ptr + 1'b1; carrier = !drop;
    @(negedge clk); byte_sent = 1'b0; carrier = 1'b1;
  endtask

  task automatic collide;
    @(negedge clk); collision = 1'b1;
    @(negedge clk); collision = 1'b0;
  endtask

  task automatic wait_go(input int lim, output bit got);
    got = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (retry_go) begin got = 1'b1; break; end
    end
  endtask

  task automatic wait_done(input int lim, output bit got, output bit saw_go);
    got = 1'b0; saw_go = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (retry_go) saw_go = 1'b1;
      if (done) begin got = 1'b1; break; end
    end
  endtask

  task automatic end_frame;
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
  endtask

  task automatic run_row(input vec_t v, input int idx);
    logic [PTR_W-1:0] b = PTR_W'(100 * (idx + 1));
    int  sent = 0;
    bit  colded = 1'b0;
    bit  over = 1'b0;
    bit  got, sg;
    full_duplex = v.fd; retry_dis = v.rdis;
    start_frame(b);
    while (sent < int'(v.len)) begin
      if (!colded && sent == int'(v.col_at)) begin
        colded = 1'b1;
        collide();
        chk(rewind == v.rw, "R3/R4/R6 rewind on collision", rewind, v.rw);
        if (v.rw) begin
          chk(rewind_ptr == b, "R3 rewind_ptr", rewind_ptr, b);
          wait_go(JAM + SLOT + 10, got);
          chk(got, "R10 retry_go after first collision", got, 1);
          rd_ptr = b; sent = 0;
          continue;
        end else if (!v.fd) begin
          wait_done(JAM + 10, got, sg);
          chk(got && !sg, "R6/R7 done without retry", {got, sg}, 2'b10);
          chk(status == v.st, "R6/R7 final status", status, v.st);
          over = 1'b1;
          break;
        end else begin
          chk(jam_req == 1'b0, "R4 no jam in full duplex", jam_req, 0);
        end
      end
      send_byte(v.crs && sent == 5);
      sent++;
    end
    if (!over) begin
      end_frame();
      chk(done == 1'b1, "R1 done pulse", done, 1);
      chk(status == v.st, "R1/R8 final status", status, v.st);
    end
    @(negedge clk);
    full_duplex = 1'b0; retry_dis = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit got, sg;
    logic [PTR_W-1:0] b;
    int jc;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !rewind && !jam_req && !retry_go, "R1 reset outputs idle",
        {done, rewind, jam_req, retry_go}, 0);
    chk(status == 4'b0 && attempt_num == '0, "R11 reset status/attempt",
        {status, attempt_num}, 0);

    for (int r = 0; r < 9; r++) run_row(VEC[r], r);

    // R2: retention window, then release
    b = 11'd300;
    start_frame(b);
    chk(attempt_num == 5'd1, "R11 attempt after start", attempt_num, 1);
    repeat (30) send_byte(1'b0);
    chk(free_ptr == b, "R2 free_ptr held inside window", free_ptr, b);
    repeat (34) send_byte(1'b0);
    @(negedge clk);
    chk(free_ptr == rd_ptr, "R2 free_ptr follows after window", free_ptr, rd_ptr);
    end_frame();
    chk(status == 4'b0001, "R1 status after window frame", status, 4'b0001);

    // R4: retry disabled removes retention
    retry_dis = 1'b1;
    start_frame(11'd400);
    repeat (10) send_byte(1'b0);
    @(negedge clk);
    chk(free_ptr == rd_ptr, "R4 no retention when retry disabled", free_ptr, rd_ptr);
    end_frame();
    retry_dis = 1'b0;

    // R9: jam length, done at jam fall for a late collision
    start_frame(11'd500);
    repeat (66) send_byte(1'b0);
    collide();
    jc = 0;
    while (jam_req && jc < 100) begin jc++; @(negedge clk); end
    chk(jc == JAM, "R9 jam length in bit ticks", jc, JAM);
    chk(done && status == 4'b0100, "R9 done when jam falls", {done, status}, 5'h14);

    // R5/R10/R11: sixteen collisions exhaust the attempts
    b = 11'd600;
    start_frame(b);
    for (int k = 1; k <= 16; k++) begin
      repeat (5) send_byte(1'b0);
      collide();
      if (k < 16) begin
        chk(rewind && rewind_ptr == b, "R3 rewind each early attempt", rewind_ptr, b);
        wait_go(JAM + ((1 << ((k > 10) ? 10 : k)) - 1) * SLOT + 10, got);
        chk(got, "R10 retry_go within backoff bound", got, 1);
        chk(attempt_num == ATT_W'(k + 1), "R11 attempt count after retry", attempt_num, k + 1);
        rd_ptr = b;
      end else begin
        chk(!rewind, "R5 no rewind on final attempt", rewind, 0);
        wait_done(JAM + 10, got, sg);
        chk(got && !sg, "R5 done without retry after 16 attempts", {got, sg}, 2'b10);
        chk(status == 4'b0010, "R5 retry error status", status, 4'b0010);
      end
    end

    // R5: fifteen collisions then a clean attempt
    b = 11'd700;
    start_frame(b);
    for (int k = 1; k <= 15; k++) begin
      repeat (3) send_byte(1'b0);
      collide();
      wait_go(JAM + ((1 << ((k > 10) ? 10 : k)) - 1) * SLOT + 10, got);
      if (!got) chk(got, "R5 retry_go during fifteen retries", got, 1);
      rd_ptr = b;
    end
    chk(attempt_num == 5'd16, "R11 attempt reaches sixteen", attempt_num, 16);
    repeat (70) send_byte(1'b0);
    end_frame();
    chk(done && status == 4'b0001, "R5 success on sixteenth attempt", {done, status}, 5'h11);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule